// File: doc/BRIEF.md
# Ethernet PHY Bring-Up Sequencer

This block starts an MII Ethernet transceiver without software help. It waits in idle until it sees a one-cycle start pulse. It then takes a copy of its configuration inputs and drives a fixed list of management register accesses to an external MDIO master. The MDIO master does the serial framing. The sequencer only presents one request at a time and waits for a one-cycle completion pulse.

The list runs in this order:

1. A self-clearing soft reset of the transceiver.
2. A programmable recovery wait, long enough for a reset that can last half a second.
3. A control-word write built from the link settings.
4. A second programmable settle wait.
5. Two identity register reads, checked against a fixed identity.
6. Optionally, a write that unmasks the transceiver's interrupt sources.

When the list ends, the block raises a done level. If the identity did not match, it also raises an error level. Wait lengths are counted in clock cycles.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `id_err_o` and `req_valid_o` are 0, and `req_phy_o` shows the default transceiver address 1.
- R2: A start pulse seen while idle makes `busy_o` 1. From the next cycle, the block requests a write (`req_write_o`=1) of 0x8000 to register 0 at the transceiver address sampled with the start.
- R3: A request stays valid, with all its fields unchanged, until the cycle in which `resp_done_i` is 1. No other request is presented before that.
- R4: After the cycle in which the reset write completes, the next request rises exactly N+1 cycles later, where N is the reset wait value (a 0 value gives 1 cycle).
- R5: The third access is a write to register 0. Bit 13 is the speed input (1 = 100 Mb/s), bit 12 is the autonegotiate input and bit 8 is the full-duplex input. Every other bit is 0, including bit 15.
- R6: After the control write completes, the next request rises exactly M+1 cycles later, where M is the settle wait value. That request is a read of register 2, and the read of register 3 follows it.
- R7: The identity matches only when register 2 returns 0x0007 and register 3, with its low 4 bits masked, returns 0xC0A0. On a mismatch, `id_err_o` becomes 1 and no further access is made.
- R8: With the interrupt option set and a matching identity, a final write of 0x00FF to register 30 is made. With the option clear, the sequence ends after the register 3 read.
- R9: At the end of the sequence, `done_o` becomes 1 and `busy_o` becomes 0. Both hold until the next accepted start, which clears `done_o` and `id_err_o`.
- R10: A start pulse received while busy has no effect. The sequence runs on unchanged, with the same number of accesses.
- R11: The address, link settings, interrupt option and wait values are sampled at the accepted start. Changes to them during the sequence do not alter any access or wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start command |
| phy_addr_i | input | 5 | Transceiver address on the management bus |
| autoneg_i | input | 1 | Request autonegotiation |
| full_dup_i | input | 1 | Request full duplex |
| speed100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| irq_en_i | input | 1 | Perform the interrupt-unmask write |
| rst_wait_i | input | 32 | Cycles to wait after the soft reset |
| settle_wait_i | input | 32 | Cycles to wait after the control write |
| req_valid_o | output | 1 | Management request pending |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_phy_o | output | 5 | Address of the addressed transceiver |
| req_reg_o | output | 5 | Register number |
| req_wdata_o | output | 16 | Write data |
| resp_done_i | input | 1 | Completion pulse from the management master |
| resp_rdata_i | input | 16 | Read data, valid with the completion |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |
| id_err_o | output | 1 | Identity mismatch seen |

## Verification
Every state of the sequencer is visible at the request port. A wrong state shows there as a wrong register number, wrong write data or a wrong access kind, and it shows within the request that follows it. A fault in a wait counter shows as a request that rises one or more cycles early or late, measured from the previous completion. A fault in the identity logic shows when the sequence ends: the error level is wrong, or the interrupt write is there when it should be skipped, or missing when it should be made. The bench pairs random settings and random responder latency with directed identity mismatches, zero-length waits and a start pulse issued while busy.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int MDIO_AW = 5;
  localparam int MDIO_DW = 16;

  localparam logic [MDIO_AW-1:0] REG_CTRL  = 5'd0;
  localparam logic [MDIO_AW-1:0] REG_IDHI  = 5'd2;
  localparam logic [MDIO_AW-1:0] REG_IDLO  = 5'd3;
  localparam logic [MDIO_AW-1:0] REG_IMASK = 5'd30;

  localparam logic [MDIO_DW-1:0] SOFT_RESET_WORD = 16'h8000;
  localparam logic [MDIO_DW-1:0] IMASK_WORD      = 16'h00FF;
  localparam logic [MDIO_DW-1:0] ID_HI_WANT      = 16'h0007;
  localparam logic [MDIO_DW-1:0] ID_LO_WANT      = 16'hC0A0;
  localparam logic [MDIO_DW-1:0] ID_LO_MASK      = 16'hFFF0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST_WR, ST_RST_WAIT, ST_CFG_WR,
    ST_SETTLE, ST_IDHI_RD, ST_IDLO_RD, ST_IMASK_WR
  } seq_state_e;

  function automatic logic [MDIO_DW-1:0] make_ctrl(input logic an, input logic fd,
                                                   input logic sp100);
    logic [MDIO_DW-1:0] w;
    w     = '0;
    w[12] = an;
    w[8]  = fd;
    w[13] = sp100;
    return w;
  endfunction

  function automatic logic idhi_ok(input logic [MDIO_DW-1:0] v);
    return v == ID_HI_WANT;
  endfunction

  function automatic logic idlo_ok(input logic [MDIO_DW-1:0] v);
    return (v & ID_LO_MASK) == ID_LO_WANT;
  endfunction

endpackage

// File: rtl/phy_wait_timer.sv
module phy_wait_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/phy_id_check.sv
module phy_id_check
  import phy_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hi_cap_i,
  input  logic [MDIO_DW-1:0] rdata_i,
  output logic               mismatch_o
);
  logic hi_good_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_good_q <= 1'b0;
    else if (hi_cap_i) hi_good_q <= idhi_ok(rdata_i);
  end

  // Valid in the cycle the register 3 read completes.
  assign mismatch_o = !(hi_good_q && idlo_ok(rdata_i));
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int                 CNT_W        = 32,
  parameter logic [MDIO_AW-1:0] DEF_PHY_ADDR = 5'd1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [MDIO_AW-1:0] phy_addr_i,
  input  logic               autoneg_i,
  input  logic               full_dup_i,
  input  logic               speed100_i,
  input  logic               irq_en_i,
  input  logic [CNT_W-1:0]   rst_wait_i,
  input  logic [CNT_W-1:0]   settle_wait_i,
  output logic               req_valid_o,
  output logic               req_write_o,
  output logic [MDIO_AW-1:0] req_phy_o,
  output logic [MDIO_AW-1:0] req_reg_o,
  output logic [MDIO_DW-1:0] req_wdata_o,
  input  logic               resp_done_i,
  input  logic [MDIO_DW-1:0] resp_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               id_err_o
);
  seq_state_e state_q, state_d;

  logic [MDIO_AW-1:0] addr_q;
  logic               an_q, fd_q, sp_q, irq_q;
  logic [CNT_W-1:0]   rwait_q, swait_q;
  logic               done_q, err_q;

  // Named internal events
  logic ev_start_accept, ev_access_done, ev_wait_expire, ev_id_fail;
  logic in_wait, tmr_zero, tmr_load, id_mismatch;
  logic [CNT_W-1:0] tmr_val;

  assign ev_start_accept = start_i && (state_q == ST_IDLE);
  assign ev_access_done  = req_valid_o && resp_done_i;
  assign in_wait         = (state_q == ST_RST_WAIT) || (state_q == ST_SETTLE);
  assign ev_wait_expire  = in_wait && tmr_zero;
  assign ev_id_fail      = ev_access_done && (state_q == ST_IDLO_RD) && id_mismatch;

  assign tmr_load = ev_access_done && (state_q == ST_RST_WR || state_q == ST_CFG_WR);
  assign tmr_val  = (state_q == ST_RST_WR) ? rwait_q : swait_q;

  phy_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .tick_i     (in_wait),
    .zero_o     (tmr_zero)
  );

  phy_id_check u_idchk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hi_cap_i   (ev_access_done && state_q == ST_IDHI_RD),
    .rdata_i    (resp_rdata_i),
    .mismatch_o (id_mismatch)
  );

  // Settings captured at an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= DEF_PHY_ADDR;
      an_q    <= 1'b0;
      fd_q    <= 1'b0;
      sp_q    <= 1'b0;
      irq_q   <= 1'b0;
      rwait_q <= '0;
      swait_q <= '0;
    end else if (ev_start_accept) begin
      addr_q  <= phy_addr_i;
      an_q    <= autoneg_i;
      fd_q    <= full_dup_i;
      sp_q    <= speed100_i;
      irq_q   <= irq_en_i;
      rwait_q <= rst_wait_i;
      swait_q <= settle_wait_i;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i)        state_d = ST_RST_WR;
      ST_RST_WR:   if (ev_access_done) state_d = ST_RST_WAIT;
      ST_RST_WAIT: if (tmr_zero)       state_d = ST_CFG_WR;
      ST_CFG_WR:   if (ev_access_done) state_d = ST_SETTLE;
      ST_SETTLE:   if (tmr_zero)       state_d = ST_IDHI_RD;
      ST_IDHI_RD:  if (ev_access_done) state_d = ST_IDLO_RD;
      ST_IDLO_RD:  if (ev_access_done)
                     state_d = (id_mismatch || !irq_q) ? ST_IDLE : ST_IMASK_WR;
      ST_IMASK_WR: if (ev_access_done) state_d = ST_IDLE;
      default:                         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_start_accept) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (state_q != ST_IDLE && state_d == ST_IDLE) begin
        done_q <= 1'b1;
      end
      if (ev_id_fail) err_q <= 1'b1;
    end
  end

  always_comb begin
    req_valid_o = 1'b0;
    req_write_o = 1'b0;
    req_reg_o   = '0;
    req_wdata_o = '0;
    unique case (state_q)
      ST_RST_WR: begin
        req_valid_o = 1'b1; req_write_o = 1'b1;
        req_reg_o = REG_CTRL; req_wdata_o = SOFT_RESET_WORD;
      end
      ST_CFG_WR: begin
        req_valid_o = 1'b1; req_write_o = 1'b1;
        req_reg_o = REG_CTRL; req_wdata_o = make_ctrl(an_q, fd_q, sp_q);
      end
      ST_IDHI_RD: begin
        req_valid_o = 1'b1; req_reg_o = REG_IDHI;
      end
      ST_IDLO_RD: begin
        req_valid_o = 1'b1; req_reg_o = REG_IDLO;
      end
      ST_IMASK_WR: begin
        req_valid_o = 1'b1; req_write_o = 1'b1;
        req_reg_o = REG_IMASK; req_wdata_o = IMASK_WORD;
      end
      default: ;
    endcase
  end

  assign req_phy_o = addr_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign id_err_o  = err_q;

endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk
  import phy_seq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid_o,
  input logic               req_write_o,
  input logic [MDIO_AW-1:0] req_phy_o,
  input logic [MDIO_AW-1:0] req_reg_o,
  input logic [MDIO_DW-1:0] req_wdata_o,
  input logic               resp_done_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               id_err_o,
  input logic               ev_start_accept,
  input logic               ev_id_fail
);
  AST_FIRST_IS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_accept |=> busy_o && req_valid_o && req_write_o
                        && req_reg_o == REG_CTRL && req_wdata_o == SOFT_RESET_WORD); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !resp_done_i |=> req_valid_o && $stable(req_write_o)
      && $stable(req_reg_o) && $stable(req_wdata_o) && $stable(req_phy_o)); // R3

  AST_CTRL_NO_RESET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_write_o && req_reg_o == REG_CTRL && req_wdata_o != SOFT_RESET_WORD
      |-> req_wdata_o[15] == 1'b0); // R5

  AST_ID_FAIL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_id_fail |=> id_err_o && !busy_o && !req_valid_o); // R7

  AST_IMASK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_reg_o == REG_IMASK |-> req_write_o && req_wdata_o == IMASK_WORD); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !req_valid_o); // R9

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(req_phy_o)); // R11
endmodule

bind phy_bringup_seq phy_bringup_seq_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid_o     (req_valid_o),
  .req_write_o     (req_write_o),
  .req_phy_o       (req_phy_o),
  .req_reg_o       (req_reg_o),
  .req_wdata_o     (req_wdata_o),
  .resp_done_i     (resp_done_i),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .id_err_o        (id_err_o),
  .ev_start_accept (ev_start_accept),
  .ev_id_fail      (ev_id_fail)
);

// File: tb/tb_phy_bringup_seq.sv
module tb_phy_bringup_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  phy_addr_i = '0;
  logic        autoneg_i = 1'b0, full_dup_i = 1'b0, speed100_i = 1'b0, irq_en_i = 1'b0;
  logic [31:0] rst_wait_i = '0, settle_wait_i = '0;
  logic        req_valid_o, req_write_o;
  logic [4:0]  req_phy_o, req_reg_o;
  logic [15:0] req_wdata_o;
  logic        resp_done_i = 1'b0;
  logic [15:0] resp_rdata_i = '0;
  logic        busy_o, done_o, id_err_o;

  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_bringup_seq dut (.*);

  // Behavioural management responder with a logged history
  logic [15:0] model_idhi = 16'h0007, model_idlo = 16'hC0A5;
  int          n_log = 0, lat = 0;
  bit          fresh = 1'b1;
  logic        lg_w  [0:15];
  logic [4:0]  lg_reg[0:15];
  logic [4:0]  lg_phy[0:15];
  logic [15:0] lg_dat[0:15];
  int          first_cyc[0:15];
  int          done_cyc [0:15];

  always @(negedge clk) begin
    if (!rst_n) begin
      resp_done_i = 1'b0; fresh = 1'b1; lat = 0;
    end else if (resp_done_i) begin
      resp_done_i = 1'b0; fresh = 1'b1; lat = $urandom % 4;
    end else if (req_valid_o && n_log < 16) begin
      if (fresh) begin first_cyc[n_log] = cyc; fresh = 1'b0; end
      if (lat == 0) begin
        lg_w[n_log] = req_write_o; lg_reg[n_log] = req_reg_o;
        lg_phy[n_log] = req_phy_o; lg_dat[n_log] = req_wdata_o;
        done_cyc[n_log] = cyc;
        resp_rdata_i = (req_reg_o == 5'd2) ? model_idhi :
                       (req_reg_o == 5'd3) ? model_idlo : 16'h0000;
        resp_done_i = 1'b1;
        n_log++;
      end else lat--;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_ctrl(input logic an, input logic fd, input logic sp);
    return {2'b00, sp, an, 3'b000, fd, 8'h00};
  endfunction

  function automatic bit exp_id_good(input logic [15:0] hi, input logic [15:0] lo);
    return (hi == 16'd7) && (lo[15:4] == 12'hC0A);
  endfunction

  task automatic run_seq(input logic [4:0] a, input logic an, input logic fd, input logic sp,
                         input logic irq, input int nr, input int ns,
                         input logic [15:0] hi, input logic [15:0] lo, input bit disturb);
    int n_exp;
    bit good;
    model_idhi = hi; model_idlo = lo;
    n_log = 0;
    phy_addr_i = a; autoneg_i = an; full_dup_i = fd; speed100_i = sp; irq_en_i = irq;
    rst_wait_i = nr; settle_wait_i = ns;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(busy_o === 1'b1 && done_o === 1'b0, "R2 busy after start", busy_o, 1);
    if (disturb) begin
      repeat (3) @(negedge clk);
      phy_addr_i = ~a; autoneg_i = ~an; full_dup_i = ~fd; speed100_i = ~sp;
      irq_en_i = ~irq; rst_wait_i = nr + 7; settle_wait_i = ns + 5;
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      check(busy_o === 1'b1, "R10 busy after ignored start", busy_o, 1);
    end
    for (int t = 0; t < 5000 && done_o !== 1'b1; t++) @(negedge clk);
    good  = exp_id_good(hi, lo);
    n_exp = (good && irq) ? 5 : 4;
    check(done_o === 1'b1 && busy_o === 1'b0, "R9 done and idle", {done_o, busy_o}, 2'b10);
    check(id_err_o === !good, "R7 error flag", id_err_o, !good);
    check(n_log == n_exp, disturb ? "R10 access count" : "R8 access count", n_log, n_exp);
    if (n_log >= 4) begin
      check(lg_w[0] && lg_reg[0] == 0 && lg_dat[0] == 16'h8000 && lg_phy[0] == a,
            "R2 soft reset write", lg_dat[0], 16'h8000);
      check(first_cyc[1] - done_cyc[0] == nr + 2, "R4 reset wait", first_cyc[1] - done_cyc[0], nr + 2);
      check(lg_w[1] && lg_reg[1] == 0 && lg_dat[1] == exp_ctrl(an, fd, sp) && lg_phy[1] == a,
            "R5 R11 control write", lg_dat[1], exp_ctrl(an, fd, sp));
      check(first_cyc[2] - done_cyc[1] == ns + 2, "R6 settle wait", first_cyc[2] - done_cyc[1], ns + 2);
      check(!lg_w[2] && lg_reg[2] == 2 && !lg_w[3] && lg_reg[3] == 3,
            "R6 identity reads", {lg_reg[2], lg_reg[3]}, {5'd2, 5'd3});
    end
    if (n_exp == 5 && n_log == 5)
      check(lg_w[4] && lg_reg[4] == 30 && lg_dat[4] == 16'h00FF, "R8 unmask write", lg_dat[4], 16'h00FF);
    repeat (4) @(negedge clk);
    check(done_o === 1'b1 && n_log == n_exp, "R9 done holds", n_log, n_exp);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(busy_o === 0 && done_o === 0 && id_err_o === 0 && req_valid_o === 0,
          "R1 outputs after reset", {busy_o, done_o, id_err_o, req_valid_o}, 0);
    check(req_phy_o === 5'd1, "R1 default address", req_phy_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o === 0 && req_valid_o === 0, "R1 idle without start", busy_o, 0);
    // Directed corners
    run_seq(5'd1, 1, 1, 1, 1, 0, 0, 16'h0007, 16'hC0A3, 0);
    run_seq(5'd9, 0, 1, 0, 0, 3, 1, 16'h0007, 16'hC0AF, 0);
    run_seq(5'd31, 1, 0, 1, 1, 2, 2, 16'h0006, 16'hC0A0, 0);
    run_seq(5'd4, 1, 1, 0, 1, 1, 3, 16'h0007, 16'hC0B0, 0);
    run_seq(5'd17, 0, 0, 1, 1, 300, 40, 16'h0007, 16'hC0A0, 0);
    run_seq(5'd6, 1, 0, 0, 1, 12, 9, 16'h0007, 16'hC0A1, 1);
    // Random runs
    for (int i = 0; i < 20; i++) begin
      logic [15:0] hi, lo;
      hi = ($urandom % 4 == 0) ? 16'h0003 : 16'h0007;
      lo = ($urandom % 4 == 0) ? 16'h1234 : (16'hC0A0 | ($urandom % 16));
      run_seq($urandom % 32, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
              $urandom % 30, $urandom % 30, hi, lo, ($urandom % 3) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule